// File: doc/BRIEF.md
# Energy-to-Frequency Pulse Generator

This block turns streams of accumulated energy increments into calibration pulse trains. The pulse rate of each train is proportional to the power that produced the increments. There are two independent channels. Each channel has its own increment input, its own scaling ratio, its own pin enable and its own sticky pulse flag. The scaling ratio is a 16-bit numerator over a 16-bit denominator. Correct operation requires the numerator to be smaller than the denominator.

On every valid increment, the channel multiplies the increment by the active numerator and adds the product to a residue accumulator. While the residue is at or above the active denominator and the output stage is idle, the channel issues a pulse and subtracts the denominator from the residue. This lets a single large increment leave a backlog that drains one pulse at a time. Each pulse drives the pin high for a fixed number of system clocks, and only when the pin is enabled. The flag is raised for every pulse, whether or not the pin is enabled.

A ratio write is held in a shadow stage. It becomes active only at a pulse boundary, so a pulse is never scaled by part of one ratio and part of another. A denominator of zero acts as one.

Top module: `e2f_pulse_gen`

## Requirements
- R1: After reset every pin is low, every flag is clear, and the active numerator is zero, so no pulse is issued until a ratio has been written and applied.
- R2: The number of pulses a channel issues equals floor(sum of increments × numerator / denominator). The remainder carries over to later increments.
- R3: A denominator written as zero behaves exactly like a denominator of one.
- R4: Each enabled pulse holds the pin high for exactly PW_CYCLES clocks (default 4). Consecutive pulses are separated by at least one low clock. A backlog left by one large increment is drained completely.
- R5: A written ratio becomes active only at a boundary: the clock in which a pulse is issued, or a clock in which the residue is zero and no increment arrives. A write made while residue is pending leaves the old ratio in force until the next pulse.
- R6: The flag of a channel is set by every pulse it issues, even with the pin disabled. It stays set until the matching flag_clr bit is pulsed, and a set wins over a simultaneous clear.
- R7: While the pin enable of a channel is low at the start of a pulse, the pin stays low for that pulse.
- R8: Channels share nothing. Increments, ratios and enables of one channel have no effect on the pulses of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inc_vld | input | N_CH | Per-channel increment strobe |
| inc_amt | input | N_CH*IW | Per-channel increment value; channel c uses bits [c*IW +: IW] |
| cfg_wr | input | N_CH | Per-channel ratio write strobe |
| cfg_num | input | RW | Numerator for a ratio write |
| cfg_den | input | RW | Denominator for a ratio write |
| pin_en | input | N_CH | Per-channel pulse pin enable |
| flag_clr | input | N_CH | Per-channel flag clear pulse |
| pulse_pin | output | N_CH | Per-channel pulse output |
| pulse_flag | output | N_CH | Per-channel sticky pulse flag |

## Verification
The hardest case to reach from the ports is a ratio write that lands while residue is still pending. Reaching it means the first increments must leave a remainder below the old denominator but at or above the new one. The bench applies a ratio, feeds two unit increments, and only then writes a smaller denominator. Because of the numbers chosen, deferred and immediate application give different pulse counts: deferral yields two pulses, while applying the write at once would yield three. The backlog drain is reached with a single increment whose product is ten times the denominator. That pulse train is used to measure every high width.

// File: rtl/e2f_pkg.sv
package e2f_pkg;
    parameter int unsigned E2F_CHANNELS  = 2;
    parameter int unsigned E2F_INC_WIDTH = 16;
    parameter int unsigned E2F_RAT_WIDTH = 16;
    parameter int unsigned E2F_PW_CLOCKS = 4;
endpackage

// File: rtl/e2f_ratio_shadow.sv
module e2f_ratio_shadow #(
    parameter int unsigned RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [RW-1:0] wr_num,
    input  logic [RW-1:0] wr_den,
    input  logic          apply,
    output logic [RW-1:0] num_act,
    output logic [RW-1:0] den_eff
);
    typedef struct packed {
        logic [RW-1:0] num_a;
        logic [RW-1:0] den_a;
        logic [RW-1:0] num_p;
        logic [RW-1:0] den_p;
        logic          pend;
    } shadow_t;

    shadow_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (apply && s_q.pend) begin
            s_d.num_a = s_q.num_p;
            s_d.den_a = s_q.den_p;
            s_d.pend  = 1'b0;
        end
        if (wr) begin
            s_d.num_p = wr_num;
            s_d.den_p = wr_den;
            s_d.pend  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.den_a <= RW'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign num_act = s_q.num_a;
    assign den_eff = (s_q.den_a == '0) ? RW'(1) : s_q.den_a;

    // R5: active ratio only moves at a boundary
    a_r5_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> ($stable(num_act) && $stable(den_eff)));
endmodule

// File: rtl/e2f_residue_acc.sv
module e2f_residue_acc #(
    parameter int unsigned IW = 16,
    parameter int unsigned RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_vld,
    input  logic [IW-1:0] inc_amt,
    input  logic [RW-1:0] num,
    input  logic [RW-1:0] den,
    input  logic          ready,
    output logic          fire,
    output logic          boundary
);
    localparam int unsigned PRW = IW + RW;
    localparam int unsigned AW  = PRW + 2;

    typedef struct packed {
        logic [AW-1:0] acc;
    } acc_t;

    acc_t a_d, a_q;
    logic [PRW-1:0] prod;
    logic [AW:0]    sum;
    logic [AW:0]    take;
    logic [AW:0]    rest;

    always_comb begin
        prod     = PRW'(inc_amt) * PRW'(num);
        fire     = ready && (a_q.acc >= AW'(den));
        sum      = (AW+1)'(a_q.acc) + (inc_vld ? (AW+1)'(prod) : '0);
        take     = fire ? (AW+1)'(den) : '0;
        rest     = sum - take;
        a_d      = a_q;
        a_d.acc  = rest[AW] ? '1 : rest[AW-1:0];
        boundary = fire || ((a_q.acc == '0) && !inc_vld);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    // R2: residue is untouched when nothing arrives and nothing is issued
    a_r2_residue_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_vld && !fire) |=> $stable(a_q.acc));
endmodule

// File: rtl/e2f_pulse_shaper.sv
module e2f_pulse_shaper #(
    parameter int unsigned PW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic pin_en,
    input  logic flag_clr,
    output logic ready,
    output logic pulse_pin,
    output logic pulse_flag
);
    localparam int unsigned CW = $clog2(PW + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          en_cap;
        logic          pin;
        logic          flag;
    } shp_t;

    shp_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (fire) begin
            p_d.cnt    = CW'(PW);
            p_d.en_cap = pin_en;
        end else if (p_q.cnt != '0) begin
            p_d.cnt = p_q.cnt - CW'(1);
        end
        p_d.pin  = (p_d.cnt != '0) && p_d.en_cap;
        p_d.flag = fire || (p_q.flag && !flag_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign ready      = (p_q.cnt == '0);
    assign pulse_pin  = p_q.pin;
    assign pulse_flag = p_q.flag;

    // R4: a pulse never starts while the previous one is still high
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !p_q.pin);
    // R6: every issued pulse leaves the flag set
    a_r6_flag_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> pulse_flag);
    // R7: a pulse started with the pin disabled stays off the pin
    a_r7_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !pin_en) |=> !pulse_pin);
endmodule

// File: rtl/e2f_channel.sv
module e2f_channel #(
    parameter int unsigned IW = 16,
    parameter int unsigned RW = 16,
    parameter int unsigned PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_vld,
    input  logic [IW-1:0] inc_amt,
    input  logic          cfg_wr,
    input  logic [RW-1:0] cfg_num,
    input  logic [RW-1:0] cfg_den,
    input  logic          pin_en,
    input  logic          flag_clr,
    output logic          pulse_pin,
    output logic          pulse_flag
);
    logic [RW-1:0] num_act;
    logic [RW-1:0] den_eff;
    logic          fire;
    logic          boundary;
    logic          ready;

    e2f_ratio_shadow #(.RW(RW)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .wr_num  (cfg_num),
        .wr_den  (cfg_den),
        .apply   (boundary),
        .num_act (num_act),
        .den_eff (den_eff)
    );

    e2f_residue_acc #(.IW(IW), .RW(RW)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_vld  (inc_vld),
        .inc_amt  (inc_amt),
        .num      (num_act),
        .den      (den_eff),
        .ready    (ready),
        .fire     (fire),
        .boundary (boundary)
    );

    e2f_pulse_shaper #(.PW(PW)) u_shaper (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .pin_en     (pin_en),
        .flag_clr   (flag_clr),
        .ready      (ready),
        .pulse_pin  (pulse_pin),
        .pulse_flag (pulse_flag)
    );
endmodule

// File: rtl/e2f_pulse_gen.sv
module e2f_pulse_gen
    import e2f_pkg::*;
#(
    parameter int unsigned N_CH = E2F_CHANNELS,
    parameter int unsigned IW   = E2F_INC_WIDTH,
    parameter int unsigned RW   = E2F_RAT_WIDTH,
    parameter int unsigned PW   = E2F_PW_CLOCKS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CH-1:0]    inc_vld,
    input  logic [N_CH*IW-1:0] inc_amt,
    input  logic [N_CH-1:0]    cfg_wr,
    input  logic [RW-1:0]      cfg_num,
    input  logic [RW-1:0]      cfg_den,
    input  logic [N_CH-1:0]    pin_en,
    input  logic [N_CH-1:0]    flag_clr,
    output logic [N_CH-1:0]    pulse_pin,
    output logic [N_CH-1:0]    pulse_flag
);
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        e2f_channel #(.IW(IW), .RW(RW), .PW(PW)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .inc_vld    (inc_vld[c]),
            .inc_amt    (inc_amt[c*IW +: IW]),
            .cfg_wr     (cfg_wr[c]),
            .cfg_num    (cfg_num),
            .cfg_den    (cfg_den),
            .pin_en     (pin_en[c]),
            .flag_clr   (flag_clr[c]),
            .pulse_pin  (pulse_pin[c]),
            .pulse_flag (pulse_flag[c])
        );
    end

    // R1: reset leaves all outputs quiet
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (pulse_pin == '0 && pulse_flag == '0));
endmodule

// File: tb/sim_e2f_pulse_gen.sv
`timescale 1ns/1ps
module sim_e2f_pulse_gen;
    localparam int PW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  inc_vld = '0;
    logic [31:0] inc_amt = '0;
    logic [1:0]  cfg_wr = '0;
    logic [15:0] cfg_num = '0;
    logic [15:0] cfg_den = '0;
    logic [1:0]  pin_en = 2'b11;
    logic [1:0]  flag_clr = '0;
    logic [1:0]  pulse_pin;
    logic [1:0]  pulse_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int pcnt[2];
    int run[2];
    int wmin[2];
    int wmax[2];
    logic prev[2];

    always #2.5 clk = ~clk;

    e2f_pulse_gen u0 (
        .clk(clk), .rst_n(rst_n), .inc_vld(inc_vld), .inc_amt(inc_amt),
        .cfg_wr(cfg_wr), .cfg_num(cfg_num), .cfg_den(cfg_den),
        .pin_en(pin_en), .flag_clr(flag_clr),
        .pulse_pin(pulse_pin), .pulse_flag(pulse_flag)
    );

    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (pulse_pin[i] && !prev[i]) begin
                pcnt[i]++;
                run[i] = 1;
            end else if (pulse_pin[i]) begin
                run[i]++;
            end else if (prev[i]) begin
                if (run[i] < wmin[i]) wmin[i] = run[i];
                if (run[i] > wmax[i]) wmax[i] = run[i];
            end
            prev[i] = pulse_pin[i];
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mon_clear();
        for (int i = 0; i < 2; i++) begin
            pcnt[i] = 0; run[i] = 0; wmin[i] = 1000; wmax[i] = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; inc_vld = '0; cfg_wr = '0; flag_clr = '0; pin_en = 2'b11;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        mon_clear();
    endtask

    task automatic cfg(int ch, int num, int den);
        @(negedge clk);
        cfg_wr = '0; cfg_wr[ch] = 1'b1;
        cfg_num = 16'(num); cfg_den = 16'(den);
        @(negedge clk);
        cfg_wr = '0;
        idle(3);
    endtask

    task automatic feed(int ch, int amt);
        @(negedge clk);
        inc_vld[ch] = 1'b1; inc_amt[ch*16 +: 16] = 16'(amt);
        @(negedge clk);
        inc_vld[ch] = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 pins low after reset", int'(pulse_pin), 0);
        chk("R1 flags clear after reset", int'(pulse_flag), 0);
        feed(0, 100);
        idle(20);
        chk("R1 no pulse before ratio written", pcnt[0], 0);
    endtask

    task automatic t_basic();
        do_reset();
        cfg(0, 1, 4);
        for (int k = 0; k < 20; k++) begin feed(0, 1); idle(PW + 2); end
        idle(20);
        chk("R2 count 20*1/4", pcnt[0], 5);
        chk("R6 flag after pulses", int'(pulse_flag[0]), 1);
        chk("R8 idle channel silent", pcnt[1], 0);
    endtask

    task automatic t_fraction();
        do_reset();
        cfg(0, 3, 10);
        for (int k = 0; k < 10; k++) begin feed(0, 7); idle(PW + 2); end
        idle(30);
        chk("R2 count 70*3/10", pcnt[0], 21);
    endtask

    task automatic t_burst();
        do_reset();
        cfg(0, 5, 8);
        feed(0, 16);
        idle(10 * (PW + 1) + 20);
        chk("R4 backlog drained 80/8", pcnt[0], 10);
        chk("R4 min high width", wmin[0], PW);
        chk("R4 max high width", wmax[0], PW);
    endtask

    task automatic t_disabled();
        do_reset();
        pin_en[0] = 1'b0;
        cfg(0, 1, 2);
        feed(0, 4);
        idle(20);
        chk("R7 pin stays low when disabled", pcnt[0], 0);
        chk("R6 flag set with pin disabled", int'(pulse_flag[0]), 1);
        @(negedge clk); flag_clr[0] = 1'b1;
        @(negedge clk); flag_clr[0] = 1'b0;
        idle(2);
        chk("R6 flag cleared by flag_clr", int'(pulse_flag[0]), 0);
        pin_en[0] = 1'b1;
    endtask

    task automatic t_den_zero();
        do_reset();
        cfg(0, 1, 0);
        for (int k = 0; k < 5; k++) begin feed(0, 1); idle(PW + 2); end
        idle(10);
        chk("R3 zero denominator acts as one", pcnt[0], 5);
    endtask

    task automatic t_deferred();
        do_reset();
        cfg(0, 1, 4);
        feed(0, 1); feed(0, 1);
        idle(3);
        cfg(0, 1, 2);
        idle(10);
        chk("R5 no pulse from pending write", pcnt[0], 0);
        feed(0, 1); feed(0, 1);
        idle(10);
        feed(0, 1); feed(0, 1);
        idle(20);
        chk("R5 write deferred to pulse boundary", pcnt[0], 2);
    endtask

    task automatic t_indep();
        do_reset();
        cfg(0, 1, 4);
        cfg(1, 3, 5);
        @(negedge clk);
        inc_vld = 2'b11; inc_amt = {16'd10, 16'd10};
        @(negedge clk);
        inc_vld = '0;
        idle(60);
        chk("R8 channel 0 count", pcnt[0], 2);
        chk("R8 channel 1 count", pcnt[1], 6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        mon_clear();
        for (int i = 0; i < 2; i++) prev[i] = 1'b0;
        t_reset();
        t_basic();
        t_fraction();
        t_burst();
        t_disabled();
        t_den_zero();
        t_deferred();
        t_indep();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule